// File: doc/BRIEF.md
# Signed Comparator Driven by Subtraction Flags

This block compares two signed two's-complement operands, `x_i` and `y_i`, whose width is a parameter (4 bits by default, 2 at minimum). It does not use a dedicated magnitude comparator. Instead, a ripple subtractor forms `x_i - y_i`, and three status flags are taken from that difference: a zero flag, a sign (negative) flag and a signed-overflow flag.

A small decoder turns those three flags into five relations: equal, less-than, less-or-equal, greater-than and greater-or-equal. Less-than is the exclusive-OR of the sign and overflow flags. This stays correct when operands of opposite sign overflow and the sign of the difference is flipped.

The block is purely combinational. It has no clock and no state. The difference and the raw flags are also brought out, so the flags can feed other status logic.

Top module: `signed_flag_cmp`

## Requirements
- R1: `diff_o` equals `x_i - y_i` reduced modulo 2^W, formed as `x_i + ~y_i + 1`.
- R2: `zero_o` is 1 exactly when every bit of `diff_o` is 0.
- R3: `neg_o` equals bit W-1 (the sign bit) of `diff_o`.
- R4: `ovf_o` is 1 exactly when the operands have different sign bits and the sign bit of `diff_o` differs from the sign bit of `x_i`. Equivalently, the true difference lies outside [-2^(W-1), 2^(W-1)-1].
- R5: `lt_o` equals `neg_o XOR ovf_o`, and this matches signed `x_i < y_i` for every operand pair, including pairs that overflow.
- R6: `eq_o` equals `zero_o`, which is 1 exactly when `x_i == y_i`.
- R7: `le_o` equals `zero_o OR (neg_o XOR ovf_o)`, that is signed `x_i <= y_i`.
- R8: `gt_o` is the complement of `le_o`, and `ge_o` is the complement of `lt_o`.
- R9: For every operand pair, exactly one of `lt_o`, `eq_o`, `gt_o` is 1.
- R10: All outputs are combinational. They are valid within the same cycle in which the operands change, with no register delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | W | Minuend, signed two's complement |
| y_i | input | W | Subtrahend, signed two's complement |
| diff_o | output | W | Wrapped difference x_i - y_i |
| zero_o | output | 1 | Difference is all zeros |
| neg_o | output | 1 | Sign bit of the difference |
| ovf_o | output | 1 | Signed overflow of the subtraction |
| eq_o | output | 1 | x_i equals y_i |
| lt_o | output | 1 | x_i less than y_i (signed) |
| le_o | output | 1 | x_i less than or equal to y_i (signed) |
| gt_o | output | 1 | x_i greater than y_i (signed) |
| ge_o | output | 1 | x_i greater than or equal to y_i (signed) |

## Verification
The overflow flag and the less-than decision can both be active for the same operand pair. When a negative minuend meets a positive subtrahend, or the reverse, with large enough magnitudes, the difference wraps and its sign bit reads the wrong way. The less-than output must then follow the overflow flag and not the sign. The bench provokes this by sweeping all operand pairs, which includes the extremes such as -8 minus 1 and 7 minus -1. It judges every output against an integer subtraction and an integer signed compare that are computed independently of the design.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    // Status flags derived from the subtraction result
    typedef struct packed {
        logic zero;
        logic neg;
        logic ovf;
    } sfc_flags_t;

    // The five signed relations
    typedef struct packed {
        logic eq;
        logic lt;
        logic le;
        logic gt;
        logic ge;
    } sfc_rel_t;

    // Sum output of one full-adder cell
    function automatic logic fa_sum(input logic a, input logic b, input logic cin);
        return a ^ b ^ cin;
    endfunction

    // Carry output of one full-adder cell
    function automatic logic fa_carry(input logic a, input logic b, input logic cin);
        return (a & b) | (a & cin) | (b & cin);
    endfunction

    // Relations decoded from the flags only
    function automatic sfc_rel_t rel_from_flags(input sfc_flags_t f);
        sfc_rel_t r;
        logic     below;
        below = f.neg ^ f.ovf;
        r.eq  = f.zero;
        r.lt  = below;
        r.le  = f.zero | below;
        r.gt  = ~(f.zero | below);
        r.ge  = ~below;
        return r;
    endfunction

endpackage

// File: rtl/sfc_subtractor.sv
module sfc_subtractor #(
    parameter int W = 4
) (
    input  logic [W-1:0] minuend_i,
    input  logic [W-1:0] subtrahend_i,
    output logic [W-1:0] diff_o
);
    import sfc_pkg::*;

    logic [W-1:0] sub_inv;
    logic [W-1:0] carry;

    assign sub_inv  = ~subtrahend_i;
    // The +1 of the two's-complement negation enters as the carry into bit 0
    assign carry[0] = 1'b1;

    for (genvar i = 0; i < W; i++) begin : g_cell
        assign diff_o[i] = fa_sum(minuend_i[i], sub_inv[i], carry[i]);
        if (i < W - 1) begin : g_carry
            assign carry[i+1] = fa_carry(minuend_i[i], sub_inv[i], carry[i]);
        end
    end

    // R1
    always_comb begin
        diff_wrap_chk: assert (diff_o == W'(minuend_i - subtrahend_i))
            else $error("ripple difference disagrees with arithmetic difference");
    end

endmodule

// File: rtl/sfc_flag_unit.sv
module sfc_flag_unit #(
    parameter int W = 4
) (
    input  logic [W-1:0]        diff_i,
    input  logic                x_msb_i,
    input  logic                y_msb_i,
    output sfc_pkg::sfc_flags_t flags_o
);
    import sfc_pkg::*;

    localparam int MSB = W - 1;

    logic [W-1:0] any_set;

    // Running OR over the difference bits, from the low end upwards
    assign any_set[0] = diff_i[0];
    for (genvar i = 1; i < W; i++) begin : g_or
        assign any_set[i] = any_set[i-1] | diff_i[i];
    end

    assign flags_o.zero = ~any_set[MSB];
    assign flags_o.neg  = diff_i[MSB];
    assign flags_o.ovf  = (x_msb_i ^ y_msb_i) & (x_msb_i ^ diff_i[MSB]);

    // R4
    always_comb begin
        if (x_msb_i == y_msb_i) begin
            no_overflow_chk: assert (!flags_o.ovf)
                else $error("overflow flagged for operands of equal sign");
        end
    end

    // R2
    always_comb begin
        if (flags_o.zero) begin
            zero_sign_chk: assert (!flags_o.neg && !flags_o.ovf)
                else $error("zero result carries sign or overflow");
        end
    end

endmodule

// File: rtl/sfc_rel_decode.sv
module sfc_rel_decode (
    input  sfc_pkg::sfc_flags_t flags_i,
    output sfc_pkg::sfc_rel_t   rel_o
);
    import sfc_pkg::*;

    assign rel_o = rel_from_flags(flags_i);

    // R9
    always_comb begin
        one_relation_chk: assert ($onehot({rel_o.lt, rel_o.eq, rel_o.gt}))
            else $error("lt/eq/gt not exactly one-hot");
    end

    // R8
    always_comb begin
        complement_chk: assert ((rel_o.ge != rel_o.lt) && (rel_o.gt != rel_o.le))
            else $error("complementary relations disagree");
    end

endmodule

// File: rtl/signed_flag_cmp.sv
module signed_flag_cmp #(
    parameter int W = 4
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic [W-1:0] diff_o,
    output logic         zero_o,
    output logic         neg_o,
    output logic         ovf_o,
    output logic         eq_o,
    output logic         lt_o,
    output logic         le_o,
    output logic         gt_o,
    output logic         ge_o
);
    import sfc_pkg::*;

    localparam int MSB = W - 1;

    sfc_flags_t flags;
    sfc_rel_t   rel;

    initial begin
        width_min_chk: assert (W >= 2) else $error("operand width must be at least 2");
    end

    sfc_subtractor #(.W(W)) u_sub (
        .minuend_i    (x_i),
        .subtrahend_i (y_i),
        .diff_o       (diff_o)
    );

    sfc_flag_unit #(.W(W)) u_flags (
        .diff_i  (diff_o),
        .x_msb_i (x_i[MSB]),
        .y_msb_i (y_i[MSB]),
        .flags_o (flags)
    );

    sfc_rel_decode u_rel (
        .flags_i (flags),
        .rel_o   (rel)
    );

    assign zero_o = flags.zero;
    assign neg_o  = flags.neg;
    assign ovf_o  = flags.ovf;
    assign eq_o   = rel.eq;
    assign lt_o   = rel.lt;
    assign le_o   = rel.le;
    assign gt_o   = rel.gt;
    assign ge_o   = rel.ge;

    // R5
    always_comb begin
        lt_signed_chk: assert (lt_o == ($signed(x_i) < $signed(y_i)))
            else $error("flag-derived less-than disagrees with signed compare");
    end

    // R6
    always_comb begin
        eq_operands_chk: assert (eq_o == (x_i == y_i))
            else $error("equal output disagrees with operands");
    end

endmodule

// File: tb/signed_flag_cmp_bench.sv
module signed_flag_cmp_bench;

    localparam int W    = 4;
    localparam int SPAN = 1 << W;
    localparam int LO   = -(1 << (W - 1));
    localparam int HI   = (1 << (W - 1)) - 1;

    typedef struct {
        logic [W-1:0] x;
        logic [W-1:0] y;
        logic [W-1:0] diff;
        logic zero, neg, ovf, eq, lt, le, gt, ge;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] x_i = '0;
    logic [W-1:0] y_i = '0;
    logic [W-1:0] diff_o;
    logic zero_o, neg_o, ovf_o, eq_o, lt_o, le_o, gt_o, ge_o;

    int compared   = 0;
    int mismatched = 0;
    int cycles     = 0;
    bit driver_done = 1'b0;
    item_t sb_q[$];

    always #5 clk = ~clk;

    signed_flag_cmp #(.W(W)) u_signed_flag_cmp (
        .x_i(x_i), .y_i(y_i), .diff_o(diff_o),
        .zero_o(zero_o), .neg_o(neg_o), .ovf_o(ovf_o),
        .eq_o(eq_o), .lt_o(lt_o), .le_o(le_o), .gt_o(gt_o), .ge_o(ge_o)
    );

    task automatic check_bit(input string req, input string name, input logic act, input logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0b expected %0b (x=%0h y=%0h)", req, name, act, exp, x_i, y_i);
        end
    endtask

    // Driver: apply one operand pair and record the expected outputs
    task automatic drive(input int sx, input int sy);
        item_t it;
        int d;
        @(posedge clk);
        x_i = W'(sx);
        y_i = W'(sy);
        d = sx - sy;
        it.x    = W'(sx);
        it.y    = W'(sy);
        it.diff = W'(d);
        it.zero = (it.diff == '0);
        it.neg  = it.diff[W-1];
        it.ovf  = (d < LO) || (d > HI);
        it.eq   = (sx == sy);
        it.lt   = (sx < sy);
        it.le   = (sx <= sy);
        it.gt   = (sx > sy);
        it.ge   = (sx >= sy);
        sb_q.push_back(it);
    endtask

    // Monitor: half a cycle after each change, compare against the queue (R10)
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t e;
                e = sb_q.pop_front();
                compared++;
                if (diff_o !== e.diff) begin
                    mismatched++;
                    $display("FAIL R1 diff: actual %0h expected %0h (x=%0h y=%0h)", diff_o, e.diff, e.x, e.y);
                end
                check_bit("R2", "zero", zero_o, e.zero);
                check_bit("R3", "neg", neg_o, e.neg);
                check_bit("R4", "ovf", ovf_o, e.ovf);
                check_bit("R5", "lt", lt_o, e.lt);
                check_bit("R6", "eq", eq_o, e.eq);
                check_bit("R7", "le", le_o, e.le);
                check_bit("R8", "gt", gt_o, e.gt);
                check_bit("R8", "ge", ge_o, e.ge);
                check_bit("R9", "one-hot lt/eq/gt", 1'b1,
                          ((lt_o + eq_o + gt_o) == 2'd1) ? 1'b1 : 1'b0);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Initial state with both operands zero: equal, no flags (R2, R6)
        drive(0, 0);
        // Overflow corner cases that flip the difference sign (R4, R5)
        drive(LO, 1);
        drive(HI, -1);
        drive(LO, HI);
        drive(HI, LO);
        drive(LO, LO);
        // Exhaustive sweep over every operand pair (R1..R10)
        for (int a = LO; a <= HI; a++) begin
            for (int b = LO; b <= HI; b++) begin
                drive(a, b);
            end
        end
        driver_done = 1'b1;
        while (sb_q.size() > 0) @(posedge clk);
        @(posedge clk);
        if (SPAN * SPAN + 6 > 0)
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule